// File: doc/BRIEF.md
# LNS Power-Ratio Unit

This unit evaluates the logarithm of a quotient of two general powers, A raised to e1 over B raised to e2, for values held in a 19-bit logarithmic number format. Because A and B are already stored as base-2 logarithms, the quotient reduces to Z = a*e1 - b*e2. Here a and b are the log fields of the two operands. The exponents e1 and e2 come from two small tables that are selected by a model-order index. The quotient is therefore handled as a single operation instead of a chain of power and divide steps.

Before any operation is issued, the host loads both exponent tables through a write port of their own. Operands then flow through a three-stage pipeline: a table read, two fixed-point multiplies, and a full-width subtract followed by truncation and saturation. Both the input and the output use valid/ready handshakes. The pipeline either advances as a whole or stalls as a whole. It advances whenever its output register is empty or is being taken. Otherwise every stage holds, and `in_ready` is low. The unit takes one operation per clock for as long as `out_ready` stays high.

LNS word format: bit 18 is the sign and bits 17:0 are a two's complement log2 magnitude with 12 fractional bits. A log field of 0x20000 is reserved for special values. With the sign bit clear it means zero, giving word 0x20000. With the sign bit set it means NaN, giving word 0x60000. Each exponent is 16-bit unsigned with 8 fractional bits.

Top module: `lnspr_power_ratio`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For ordinary operands with an order index from 0 to 20, the output log field is floor((a*e1 - b*e2) / 256), computed at full precision. The output sign bit is 0.
- R3: An operation accepted on a rising edge reaches the output after exactly three rising edges, counting the accepting edge. Back-to-back operations come out on consecutive cycles, in order.
- R4: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, `out_z` holds its value, and no operation is lost or reordered.
- R5: A result above +131071 LSB saturates to log field 0x1FFFF, giving output word 0x1FFFF.
- R6: A result below -131071 LSB saturates to log field 0x20001. The unit never produces the zero word 0x20000.
- R7: If either operand has log field 0x20000 (zero or NaN), the output is the NaN word 0x60000.
- R8: A table write with `tbl_wr_en` high loads `tbl_wr_e1` and `tbl_wr_e2` into entry `tbl_wr_idx`. A write to an index above 20 changes no entry.
- R9: An operation with an order index above 20 yields NaN (0x60000).
- R10: The sign bit of an ordinary operand is ignored, because only |A| and |B| enter the result.
- R11: A table write in the same cycle as an accepted operation reads the old entry for that operation. Operations accepted later see the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when high with in_valid |
| in_a | input | 19 | Operand A, LNS word |
| in_b | input | 19 | Operand B, LNS word |
| in_order | input | 5 | Order index selecting e1 and e2 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_z | output | 19 | Result, LNS word |
| tbl_wr_en | input | 1 | Exponent table write strobe |
| tbl_wr_idx | input | 5 | Table entry to write |
| tbl_wr_e1 | input | 16 | Numerator exponent, 8 fractional bits |
| tbl_wr_e2 | input | 16 | Denominator exponent, 8 fractional bits |

## Verification
The hardest case to create is a stall that arrives while the pipeline is completely full. In that case three operations sit in flight and a fourth is waiting at the input. The bench issues three operations back to back with `out_ready` held low, and then offers a fourth. It holds the stall for several cycles, checking that the output is stable and that `in_ready` stays low. It then releases the stall and expects the remaining three results in order, on consecutive cycles. A second hard case is a table write to an index in the same cycle that an operation reads that index. The bench lines both up on one clock edge, then follows with another operation to show that the new value has taken effect.

// File: rtl/lnspr_pkg.sv
`timescale 1ns/1ps
package lnspr_pkg;
  // default geometry of the log-domain word and exponent tables
  localparam int LOG_W_DEF      = 18;
  localparam int FRAC_W_DEF     = 12;
  localparam int EXP_W_DEF      = 16;
  localparam int EXP_FRAC_W_DEF = 8;
  localparam int ORDERS_DEF     = 21;

  // class of an incoming LNS word
  typedef enum logic [1:0] {
    LNS_NUM  = 2'd0,
    LNS_ZERO = 2'd1,
    LNS_NAN  = 2'd2
  } lns_class_e;
endpackage

// File: rtl/lnspr_exp_table.sv
`timescale 1ns/1ps
module lnspr_exp_table #(
  parameter int EXP_W  = 16,
  parameter int ORDERS = 21,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [EXP_W-1:0] wr_e1,
  input  logic [EXP_W-1:0] wr_e2,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [EXP_W-1:0] rd_e1,
  output logic [EXP_W-1:0] rd_e2,
  output logic             rd_bad
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ORDERS - 1);

  logic [EXP_W-1:0] e1_q [ORDERS];
  logic [EXP_W-1:0] e2_q [ORDERS];

  for (genvar g = 0; g < ORDERS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e1_q[g] <= '0;
        e2_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        e1_q[g] <= wr_e1;
        e2_q[g] <= wr_e2;
      end
    end

    // R8: a write aimed past the last order leaves every entry untouched
    p_bad_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx > TOP_IDX) |=> ($stable(e1_q[g]) && $stable(e2_q[g])));
  end

  // registered read; old contents are seen when a write lands on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_e1  <= '0;
      rd_e2  <= '0;
      rd_bad <= 1'b0;
    end else if (rd_en) begin
      rd_bad <= rd_idx > TOP_IDX;
      if (rd_idx <= TOP_IDX) begin
        rd_e1 <= e1_q[rd_idx];
        rd_e2 <= e2_q[rd_idx];
      end else begin
        rd_e1 <= '0;
        rd_e2 <= '0;
      end
    end
  end
endmodule

// File: rtl/lnspr_scale.sv
`timescale 1ns/1ps
module lnspr_scale #(
  parameter int LOG_W = 18,
  parameter int EXP_W = 16,
  parameter int PROD_W = LOG_W + EXP_W
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [LOG_W-1:0]         log_in,
  input  logic [EXP_W-1:0]         exp_in,
  output logic signed [PROD_W-1:0] prod_q
);
  // signed log times unsigned exponent; magnitude fits PROD_W bits
  logic signed [PROD_W-1:0] prod_d;
  assign prod_d = $signed(log_in) * $signed({1'b0, exp_in});

  always_ff @(posedge clk) begin
    if (en) prod_q <= prod_d;
  end
endmodule

// File: rtl/lnspr_sub_sat.sv
`timescale 1ns/1ps
module lnspr_sub_sat #(
  parameter int PROD_W = 34,
  parameter int LOG_W  = 18,
  parameter int DROP_W = 8
) (
  input  logic signed [PROD_W-1:0] p_num,
  input  logic signed [PROD_W-1:0] p_den,
  output logic [LOG_W-1:0]         field
);
  localparam int DIFF_W = PROD_W + 1;
  localparam logic signed [DIFF_W-1:0] MAX_S = DIFF_W'((2 ** (LOG_W - 1)) - 1);
  localparam logic signed [DIFF_W-1:0] MIN_S = -MAX_S;
  localparam logic [LOG_W-1:0] MAX_F = {1'b0, {(LOG_W-1){1'b1}}};
  localparam logic [LOG_W-1:0] MIN_F = {1'b1, {(LOG_W-2){1'b0}}, 1'b1};

  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] shifted;

  always_comb begin
    diff    = {p_num[PROD_W-1], p_num} - {p_den[PROD_W-1], p_den};
    shifted = diff >>> DROP_W;          // floor: truncation toward minus infinity
    if (shifted > MAX_S)      field = MAX_F;
    else if (shifted < MIN_S) field = MIN_F;
    else                      field = shifted[LOG_W-1:0];
  end
endmodule

// File: rtl/lnspr_power_ratio.sv
`timescale 1ns/1ps
module lnspr_power_ratio
  import lnspr_pkg::*;
#(
  parameter int LOG_W      = LOG_W_DEF,
  parameter int EXP_W      = EXP_W_DEF,
  parameter int EXP_FRAC_W = EXP_FRAC_W_DEF,
  parameter int ORDERS     = ORDERS_DEF,
  parameter int IDX_W      = $clog2(ORDERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LOG_W:0]   in_a,
  input  logic [LOG_W:0]   in_b,
  input  logic [IDX_W-1:0] in_order,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LOG_W:0]   out_z,
  input  logic             tbl_wr_en,
  input  logic [IDX_W-1:0] tbl_wr_idx,
  input  logic [EXP_W-1:0] tbl_wr_e1,
  input  logic [EXP_W-1:0] tbl_wr_e2
);
  localparam int PROD_W = LOG_W + EXP_W;
  localparam logic [LOG_W-1:0] FIELD_MIN = {1'b1, {(LOG_W-1){1'b0}}};
  localparam logic [LOG_W:0]   ZERO_CODE = {1'b0, FIELD_MIN};
  localparam logic [LOG_W:0]   NAN_CODE  = {1'b1, FIELD_MIN};

  function automatic lns_class_e classify(input logic [LOG_W:0] v);
    if (v[LOG_W-1:0] != FIELD_MIN) return LNS_NUM;
    else if (v[LOG_W])             return LNS_NAN;
    else                           return LNS_ZERO;
  endfunction

  // whole-pipe advance: output empty or being drained
  logic advance, accept;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;

  // stage 1: operand fields, special flag, table read
  logic             v1, spec1;
  logic [LOG_W-1:0] a1, b1;
  logic [EXP_W-1:0] e1_s1, e2_s1;
  logic             bad_s1;

  lnspr_exp_table #(.EXP_W(EXP_W), .ORDERS(ORDERS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_e1(tbl_wr_e1), .wr_e2(tbl_wr_e2),
    .rd_en(accept), .rd_idx(in_order),
    .rd_e1(e1_s1), .rd_e2(e2_s1), .rd_bad(bad_s1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      spec1 <= 1'b0;
      a1    <= '0;
      b1    <= '0;
    end else if (advance) begin
      v1 <= in_valid;
      if (in_valid) begin
        spec1 <= (classify(in_a) != LNS_NUM) || (classify(in_b) != LNS_NUM);
        a1    <= in_a[LOG_W-1:0];
        b1    <= in_b[LOG_W-1:0];
      end
    end
  end

  // stage 2: two products
  logic                     v2, nan2;
  logic signed [PROD_W-1:0] p_num, p_den;

  lnspr_scale #(.LOG_W(LOG_W), .EXP_W(EXP_W), .PROD_W(PROD_W)) u_scale_num (
    .clk(clk), .en(advance), .log_in(a1), .exp_in(e1_s1), .prod_q(p_num)
  );
  lnspr_scale #(.LOG_W(LOG_W), .EXP_W(EXP_W), .PROD_W(PROD_W)) u_scale_den (
    .clk(clk), .en(advance), .log_in(b1), .exp_in(e2_s1), .prod_q(p_den)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      nan2 <= 1'b0;
    end else if (advance) begin
      v2   <= v1;
      nan2 <= spec1 || bad_s1;
    end
  end

  // stage 3: subtract, truncate, saturate
  logic [LOG_W-1:0] field3;

  lnspr_sub_sat #(.PROD_W(PROD_W), .LOG_W(LOG_W), .DROP_W(EXP_FRAC_W)) u_sub_sat (
    .p_num(p_num), .p_den(p_den), .field(field3)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_z     <= '0;
    end else if (advance) begin
      out_valid <= v2;
      out_z     <= nan2 ? NAN_CODE : {1'b0, field3};
    end
  end

  // R2: a set sign bit only ever appears in the NaN word
  p_sign_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_z[LOG_W] || out_z == NAN_CODE));

  // R6: the zero word is never produced
  p_no_zero_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_z != ZERO_CODE));

  // R4: a refused result stays put
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_z)));

  // R4: nothing is taken in while the output is blocked
  p_block_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && in_valid) |=> $stable(v1) && $stable(a1));
endmodule

// File: tb/test_lnspr_power_ratio.sv
`timescale 1ns/1ps
module test_lnspr_power_ratio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [18:0] in_a = '0;
  logic [18:0] in_b = '0;
  logic [4:0]  in_order = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [18:0] out_z;
  logic        tbl_wr_en = 1'b0;
  logic [4:0]  tbl_wr_idx = '0;
  logic [15:0] tbl_wr_e1 = '0;
  logic [15:0] tbl_wr_e2 = '0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  localparam logic [18:0] NAN_W  = 19'h60000;
  localparam logic [18:0] ZERO_W = 19'h20000;

  logic [15:0] m_e1 [32];
  logic [15:0] m_e2 [32];

  always #10 clk = ~clk;   // 50 MHz

  lnspr_power_ratio i_lnspr_power_ratio (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_order(in_order),
    .out_valid(out_valid), .out_ready(out_ready), .out_z(out_z),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_e1(tbl_wr_e1), .tbl_wr_e2(tbl_wr_e2)
  );

  function automatic logic [18:0] model(logic [18:0] a, logic [18:0] b, logic [4:0] idx);
    longint pa, pb, d, q;
    if (a[17:0] == 18'h20000 || b[17:0] == 18'h20000 || idx > 5'd20) return NAN_W;
    pa = longint'($signed(a[17:0]));
    pb = longint'($signed(b[17:0]));
    d  = pa * longint'(m_e1[idx]) - pb * longint'(m_e2[idx]);
    q  = d >>> 8;
    if (q > 131071)  return 19'h1FFFF;
    if (q < -131071) return 19'h20001;
    return {1'b0, 18'(q)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_table(logic [4:0] idx, logic [15:0] e1, logic [15:0] e2);
    tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_e1 = e1; tbl_wr_e2 = e2;
    if (idx <= 5'd20) begin m_e1[idx] = e1; m_e2[idx] = e2; end
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // one isolated operation, result checked three edges later
  task automatic single_op(logic [18:0] a, logic [18:0] b, logic [4:0] idx, string req);
    logic [18:0] exp;
    exp = model(a, b, idx);
    in_valid = 1'b1; in_a = a; in_b = b; in_order = idx;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, {req, " not early"}, 32'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_z == exp, req, 32'(out_z), 32'(exp));
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 1);
  endtask

  task automatic t_load;
    for (int k = 0; k < 32; k++) begin m_e1[k] = '0; m_e2[k] = '0; end
    for (int k = 0; k <= 20; k++) wr_table(5'(k), 16'(16'h0100 + k * 16'h0020), 16'(16'h0080 + k * 16'h0011));
  endtask

  task automatic t_arith;
    single_op(19'h02000, 19'h01000, 5'd0, "R2 basic");
    single_op(19'h3F000, 19'h00800, 5'd7, "R2 negative log");
    single_op(19'h01234, 19'h3ABCD, 5'd20, "R2 last order");
    single_op(19'h00000, 19'h00001, 5'd3, "R2 floor of negative");
    single_op(19'h42000, 19'h41000, 5'd0, "R10 sign ignored");
  endtask

  task automatic t_saturate;
    wr_table(5'd10, 16'hFFFF, 16'h0000);
    single_op(19'h1FFFF, 19'h00000, 5'd10, "R5 high saturation");
    wr_table(5'd11, 16'h0000, 16'hFFFF);
    single_op(19'h00000, 19'h1FFFF, 5'd11, "R6 low saturation");
    check(out_z != ZERO_W, "R6 no zero word", 32'(out_z), 32'h20001);
  endtask

  task automatic t_special;
    single_op(19'h20000, 19'h01000, 5'd2, "R7 zero A");
    single_op(19'h01000, 19'h60000, 5'd2, "R7 NaN B");
    single_op(19'h01000, 19'h00800, 5'd25, "R9 bad order");
  endtask

  task automatic t_stream;
    logic [18:0] ea [5];
    for (int j = 0; j < 5; j++) ea[j] = model(19'(j * 19'h00700), 19'(19'h00100 + j), 5'(j * 4));
    for (int j = 0; j < 8; j++) begin
      if (j >= 3)
        check(out_valid && out_z == ea[j-3], "R3 back-to-back", 32'(out_z), 32'(ea[j-3]));
      if (j < 5) begin
        in_valid = 1'b1; in_a = 19'(j * 19'h00700); in_b = 19'(19'h00100 + j); in_order = 5'(j * 4);
      end else in_valid = 1'b0;
      @(negedge clk);
    end
    check(out_valid == 1'b0, "R3 drained", 32'(out_valid), 0);
  endtask

  task automatic t_backpressure;
    logic [18:0] ex [4];
    for (int j = 0; j < 4; j++) ex[j] = model(19'(19'h00400 * (j + 1)), 19'h00200, 5'(j + 1));
    out_ready = 1'b0;
    for (int j = 0; j < 3; j++) begin
      in_valid = 1'b1; in_a = 19'(19'h00400 * (j + 1)); in_b = 19'h00200; in_order = 5'(j + 1);
      @(negedge clk);
    end
    in_a = 19'h01000; in_b = 19'h00200; in_order = 5'd4;   // fourth op waits
    check(out_valid && out_z == ex[0], "R4 first held", 32'(out_z), 32'(ex[0]));
    check(in_ready == 1'b0, "R4 in_ready low", 32'(in_ready), 0);
    @(negedge clk); @(negedge clk);
    check(out_valid && out_z == ex[0], "R4 stable while stalled", 32'(out_z), 32'(ex[0]));
    check(in_ready == 1'b0, "R4 still blocked", 32'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_z == ex[1], "R4 second after release", 32'(out_z), 32'(ex[1]));
    @(negedge clk);
    check(out_valid && out_z == ex[2], "R4 third", 32'(out_z), 32'(ex[2]));
    @(negedge clk);
    check(out_valid && out_z == ex[3], "R4 waiting op not lost", 32'(out_z), 32'(ex[3]));
    @(negedge clk);
  endtask

  task automatic t_table;
    logic [18:0] e_old, e_new;
    // R8: writes beyond the last order alter nothing
    wr_table(5'd25, 16'hABCD, 16'h1234);
    wr_table(5'd31, 16'hFFFF, 16'hFFFF);
    single_op(19'h01000, 19'h00400, 5'd4, "R8 entry 4 intact");
    single_op(19'h01000, 19'h00400, 5'd9, "R8 entry 9 intact");
    single_op(19'h01000, 19'h00400, 5'd20, "R8 entry 20 intact");
    // R11: same-edge write and read
    e_old = model(19'h01000, 19'h00400, 5'd3);
    in_valid = 1'b1; in_a = 19'h01000; in_b = 19'h00400; in_order = 5'd3;
    tbl_wr_en = 1'b1; tbl_wr_idx = 5'd3; tbl_wr_e1 = 16'h0300; tbl_wr_e2 = 16'h0040;
    @(negedge clk);
    m_e1[3] = 16'h0300; m_e2[3] = 16'h0040;
    e_new = model(19'h01000, 19'h00400, 5'd3);
    tbl_wr_en = 1'b0;             // second op uses the updated entry
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_z == e_old, "R11 old entry on same edge", 32'(out_z), 32'(e_old));
    @(negedge clk);
    check(out_valid && out_z == e_new, "R11 new entry afterwards", 32'(out_z), 32'(e_new));
    @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #55;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_arith();
    t_saturate();
    t_special();
    t_stream();
    t_backpressure();
    t_table();
    summary();
  end

  initial begin
    #(20 * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule